// File: doc/BRIEF.md
# SPI Slave Chip-Select Router

This block is the SPI slave front end of a mixed I/O controller. One external SPI master shares a single active-low select line between three targets: an internal GPIO register block, an external DAC and an external ADC. When the select falls, the first byte the master shifts in is a routing address rather than payload. Once that byte is complete, the block decodes it and from then on connects the master's clock, data and a freshly generated active-low select to the chosen converter. If the address names the internal register block, the block instead interprets the following bytes as a two-command read/write protocol.

The bus runs in SPI mode 0, MSB first: MOSI is sampled on rising SCLK edges and MISO changes after falling edges. The SPI pins are oversampled by the system clock through a synchronizer. The generated converter selects are released combinationally the moment the master select rises. A rising master select at any point discards a partial transfer and clears the routing decision.

Top module: `spi_cs_router`

## Requirements
- R1: After reset and while the master select is high, both converter selects are high, both routed clocks are low, MISO is low and neither register strobe pulses.
- R2: The first byte of a transaction selects the target: 0x01 the register block, 0x02 the DAC, 0x03 the ADC. Any other value selects nothing: both converter selects stay high, no clock is routed, no strobe pulses and MISO stays low.
- R3: A converter select goes low only after the eighth falling SCLK edge of the address byte, never while the address byte is being shifted.
- R4: A converter select returns high in the same instant the master select rises, without waiting for a system clock edge.
- R5: After the address byte, SCLK and MOSI are forwarded only to the selected converter, MSB first; the other converter's routed clock stays low.
- R6: MISO is low during the address byte and whenever the master select is high; for a converter target MISO follows that converter's data output.
- R7: Register write: the second byte has bit 7 set to 1 and the register address in bits 4:0; after the third byte completes, reg_we_o pulses for exactly one clock with that address on reg_addr_o and the third byte on reg_wdata_o. Any further bytes in the same transaction cause no further write.
- R8: Register read: the second byte has bit 7 at 0, bits 6:5 ignored and the address in bits 4:0; at the end of that byte reg_re_o pulses for one clock with the address on reg_addr_o, and reg_rdata_i is returned on MISO, MSB first, during the third byte.
- R9: A master select rising mid-byte aborts the transfer: no write strobe results, and the next transaction decodes its first byte afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the SPI pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI clock from master |
| cs_ni | input | 1 | Shared active-low select from master |
| mosi_i | input | 1 | Master data out |
| miso_o | output | 1 | Data to master |
| dac_cs_no | output | 1 | Generated DAC select, active low |
| dac_sclk_o | output | 1 | Routed clock to DAC |
| dac_mosi_o | output | 1 | Routed data to DAC |
| dac_miso_i | input | 1 | Data from DAC |
| adc_cs_no | output | 1 | Generated ADC select, active low |
| adc_sclk_o | output | 1 | Routed clock to ADC |
| adc_mosi_o | output | 1 | Routed data to ADC |
| adc_miso_i | input | 1 | Data from ADC |
| reg_addr_o | output | 5 | Register address for the GPIO block |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_re_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | 8 | Register read data, valid while reg_addr_o is stable |

## Verification
Routing is driven with every defined address byte and with an undefined one, while the two converter data inputs are held at opposite levels and then swapped, so a wrong MISO source, a select asserted too early, or a clock leaking to the wrong converter each shows up as a distinct mismatch. Register traffic uses writes with and without a trailing extra byte and reads at different addresses with the ignored command bits set, so the address, data, strobe count and returned bit order are separated. Aborts are applied both inside a data byte and inside an address byte, followed by fresh transactions that expose any stale bit count or routing choice.

// File: rtl/spi_rt_pkg.sv
package spi_rt_pkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_GPIO, TGT_DAC, TGT_ADC} tgt_e;
endpackage

// File: rtl/spi_rt_sync.sv
module spi_rt_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[g] <= RST_VAL;
        else         pipe[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[g] <= RST_VAL;
        else         pipe[g] <= pipe[g-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_rt_frame.sv
module spi_rt_frame #(
  parameter int DW     = 8,
  parameter int BCNT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_s_ni,
  input  logic              mosi_s_i,
  output logic              fall_o,
  output logic              bnd_o,
  output logic [BCNT_W-1:0] byte_cnt_o,
  output logic [DW-1:0]     rx_o
);
  localparam int BIT_W = $clog2(DW);

  logic             sclk_q, pend_q, rise;
  logic [BIT_W-1:0] bit_cnt;

  assign rise   = sclk_s_i & ~sclk_q & ~cs_s_ni;
  assign fall_o = ~sclk_s_i & sclk_q & ~cs_s_ni;
  // byte boundary: first falling edge after the last bit of a byte
  assign bnd_o  = fall_o & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      pend_q     <= 1'b0;
      bit_cnt    <= '0;
      byte_cnt_o <= '0;
      rx_o       <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      if (cs_s_ni) begin
        pend_q     <= 1'b0;
        bit_cnt    <= '0;
        byte_cnt_o <= '0;
      end else begin
        if (rise) begin
          rx_o <= {rx_o[DW-2:0], mosi_s_i};
          if (bit_cnt == BIT_W'(DW-1)) begin
            bit_cnt <= '0;
            pend_q  <= 1'b1;
            if (byte_cnt_o != '1) byte_cnt_o <= byte_cnt_o + 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (bnd_o) pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_rt_gpio_cmd.sv
module spi_rt_gpio_cmd #(
  parameter int DW     = 8,
  parameter int AW     = 5,
  parameter int BCNT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_s_ni,
  input  logic              en_i,
  input  logic              fall_i,
  input  logic              bnd_i,
  input  logic [BCNT_W-1:0] byte_cnt_i,
  input  logic [DW-1:0]     rx_i,
  input  logic [DW-1:0]     reg_rdata_i,
  output logic [AW-1:0]     reg_addr_o,
  output logic [DW-1:0]     reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic              miso_o
);
  logic          wr_q, rd_act_q;
  logic [DW-1:0] tx_q;
  logic          cmd_end, dat_end;
  logic          unused_cmd_bits;

  assign unused_cmd_bits = ^rx_i[DW-2:AW];
  assign cmd_end = bnd_i & en_i & (byte_cnt_i == BCNT_W'(2));
  assign dat_end = bnd_i & en_i & (byte_cnt_i == BCNT_W'(3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q        <= 1'b0;
      rd_act_q    <= 1'b0;
      tx_q        <= '0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
    end else begin
      reg_we_o <= 1'b0;
      reg_re_o <= 1'b0;
      if (cs_s_ni) begin
        wr_q     <= 1'b0;
        rd_act_q <= 1'b0;
      end else begin
        if (cmd_end) begin
          wr_q       <= rx_i[DW-1];
          reg_addr_o <= rx_i[AW-1:0];
          reg_re_o   <= ~rx_i[DW-1];
        end
        // read data is valid the cycle the address is presented
        if (reg_re_o) begin
          tx_q     <= reg_rdata_i;
          rd_act_q <= 1'b1;
        end
        if (dat_end) begin
          rd_act_q <= 1'b0;
          if (wr_q) begin
            reg_we_o    <= 1'b1;
            reg_wdata_o <= rx_i;
          end
        end else if (fall_i && rd_act_q) begin
          tx_q <= {tx_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign miso_o = rd_act_q & tx_q[DW-1];
endmodule

// File: rtl/spi_cs_router.sv
module spi_cs_router
  import spi_rt_pkg::*;
#(
  parameter int          DW          = 8,
  parameter int          AW          = 5,
  parameter int          BCNT_W      = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [DW-1:0] GPIO_CODE = 8'h01,
  parameter logic [DW-1:0] DAC_CODE  = 8'h02,
  parameter logic [DW-1:0] ADC_CODE  = 8'h03
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          dac_cs_no,
  output logic          dac_sclk_o,
  output logic          dac_mosi_o,
  input  logic          dac_miso_i,
  output logic          adc_cs_no,
  output logic          adc_sclk_o,
  output logic          adc_mosi_o,
  input  logic          adc_miso_i,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o,
  input  logic [DW-1:0] reg_rdata_i
);
  logic              sclk_s, mosi_s, cs_s_n;
  logic              fall, bnd, gpio_miso;
  logic [BCNT_W-1:0] byte_cnt;
  logic [DW-1:0]     rx;
  tgt_e              tgt_q;
  logic              dac_sel, adc_sel;

  spi_rt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, mosi_i, cs_ni}),
    .q_o   ({sclk_s, mosi_s, cs_s_n})
  );

  spi_rt_frame #(.DW(DW), .BCNT_W(BCNT_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (sclk_s),
    .cs_s_ni   (cs_s_n),
    .mosi_s_i  (mosi_s),
    .fall_o    (fall),
    .bnd_o     (bnd),
    .byte_cnt_o(byte_cnt),
    .rx_o      (rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 tgt_q <= TGT_NONE;
    else if (cs_s_n)                             tgt_q <= TGT_NONE;
    else if (bnd && byte_cnt == BCNT_W'(1)) begin
      if      (rx == GPIO_CODE) tgt_q <= TGT_GPIO;
      else if (rx == DAC_CODE)  tgt_q <= TGT_DAC;
      else if (rx == ADC_CODE)  tgt_q <= TGT_ADC;
      else                      tgt_q <= TGT_NONE;
    end
  end

  spi_rt_gpio_cmd #(.DW(DW), .AW(AW), .BCNT_W(BCNT_W)) u_gpio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_ni    (cs_s_n),
    .en_i       (tgt_q == TGT_GPIO),
    .fall_i     (fall),
    .bnd_i      (bnd),
    .byte_cnt_i (byte_cnt),
    .rx_i       (rx),
    .reg_rdata_i(reg_rdata_i),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .reg_re_o   (reg_re_o),
    .miso_o     (gpio_miso)
  );

  // target changes only while sclk_s is low, so routed clocks start clean
  assign dac_sel    = (tgt_q == TGT_DAC);
  assign adc_sel    = (tgt_q == TGT_ADC);
  assign dac_cs_no  = ~dac_sel | cs_ni;
  assign adc_cs_no  = ~adc_sel | cs_ni;
  assign dac_sclk_o = dac_sel & sclk_s;
  assign adc_sclk_o = adc_sel & sclk_s;
  assign dac_mosi_o = dac_sel & mosi_s;
  assign adc_mosi_o = adc_sel & mosi_s;

  always_comb begin
    miso_o = 1'b0;
    if (!cs_ni) begin
      unique case (tgt_q)
        TGT_GPIO: miso_o = gpio_miso;
        TGT_DAC:  miso_o = dac_miso_i;
        TGT_ADC:  miso_o = adc_miso_i;
        default:  miso_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_router_chk.sv
module spi_cs_router_chk #(
  parameter int BCNT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              miso_o,
  input logic              dac_cs_no,
  input logic              adc_cs_no,
  input logic              dac_sclk_o,
  input logic              adc_sclk_o,
  input logic              reg_we_o,
  input logic              reg_re_o,
  input logic [BCNT_W-1:0] byte_cnt_i
);
  AST_ONE_CONVERTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dac_cs_no && !adc_cs_no)); // R2
  AST_DAC_SEL_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_cs_no) |-> (byte_cnt_i != '0)); // R3
  AST_ADC_SEL_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_cs_no) |-> (byte_cnt_i != '0)); // R3
  AST_DAC_CLK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_cs_no |-> !dac_sclk_o); // R5
  AST_ADC_CLK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_cs_no |-> !adc_sclk_o); // R5
  AST_MISO_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !miso_o); // R6
  AST_WE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R7
  AST_RE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o)); // R7
endmodule

bind spi_cs_router spi_cs_router_chk #(.BCNT_W(BCNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .miso_o    (miso_o),
  .dac_cs_no (dac_cs_no),
  .adc_cs_no (adc_cs_no),
  .dac_sclk_o(dac_sclk_o),
  .adc_sclk_o(adc_sclk_o),
  .reg_we_o  (reg_we_o),
  .reg_re_o  (reg_re_o),
  .byte_cnt_i(byte_cnt)
);

// File: tb/spi_cs_router_test.sv
`timescale 1ns/1ps
module spi_cs_router_test;
  localparam int HALF = 8;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       sclk_i = 1'b0, cs_ni = 1'b1, mosi_i = 1'b0;
  logic       dac_miso_i = 1'b0, adc_miso_i = 1'b0;
  logic       miso_o, dac_cs_no, dac_sclk_o, dac_mosi_o;
  logic       adc_cs_no, adc_sclk_o, adc_mosi_o;
  logic [4:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;
  logic       reg_we_o, reg_re_o;

  int n_chk = 0, n_fail = 0;
  int we_cnt = 0, re_cnt = 0, dac_edges = 0, adc_edges = 0;
  logic [4:0] we_addr, re_addr;
  logic [7:0] we_data, dac_cap, adc_cap;
  logic       addr_phase = 1'b0, early_sel = 1'b0, done = 1'b0;

  always #2 clk_i = ~clk_i;

  function automatic logic [7:0] rd_val(input logic [4:0] a);
    return {a[2:0], a} ^ 8'hA5;
  endfunction
  assign reg_rdata_i = rd_val(reg_addr_o);

  spi_cs_router uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_ni(cs_ni), .mosi_i(mosi_i),
    .miso_o(miso_o), .dac_cs_no(dac_cs_no), .dac_sclk_o(dac_sclk_o),
    .dac_mosi_o(dac_mosi_o), .dac_miso_i(dac_miso_i), .adc_cs_no(adc_cs_no),
    .adc_sclk_o(adc_sclk_o), .adc_mosi_o(adc_mosi_o), .adc_miso_i(adc_miso_i),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o),
    .reg_re_o(reg_re_o), .reg_rdata_i(reg_rdata_i)
  );

  always @(posedge clk_i) begin
    if (reg_we_o) begin we_cnt <= we_cnt + 1; we_addr <= reg_addr_o; we_data <= reg_wdata_o; end
    if (reg_re_o) begin re_cnt <= re_cnt + 1; re_addr <= reg_addr_o; end
  end
  always @(posedge dac_sclk_o) begin dac_edges <= dac_edges + 1; dac_cap <= {dac_cap[6:0], dac_mosi_o}; end
  always @(posedge adc_sclk_o) begin adc_edges <= adc_edges + 1; adc_cap <= {adc_cap[6:0], adc_mosi_o}; end
  always @(negedge clk_i) if (addr_phase && (!dac_cs_no || !adc_cs_no)) early_sel <= 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic clear_mon();
    we_cnt = 0; re_cnt = 0; dac_edges = 0; adc_edges = 0; early_sel = 1'b0;
  endtask

  task automatic spi_begin();
    @(negedge clk_i); cs_ni = 1'b0; wait_clks(HALF);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rxb);
    rxb = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi_i = tx[i];
      wait_clks(HALF);
      rxb[i] = miso_o;
      sclk_i = 1'b1;
      wait_clks(HALF);
      sclk_i = 1'b0;
    end
  endtask

  task automatic spi_end();
    wait_clks(HALF); cs_ni = 1'b1; mosi_i = 1'b0; wait_clks(3 * HALF);
  endtask

  task automatic t_reset();
    chk("R1 dac_cs_no", dac_cs_no, 1);
    chk("R1 adc_cs_no", adc_cs_no, 1);
    chk("R1 clocks", {dac_sclk_o, adc_sclk_o}, 0);
    chk("R1 miso", miso_o, 0);
    chk("R1 strobes", {reg_we_o, reg_re_o}, 0);
  endtask

  task automatic t_write(input logic [4:0] a, input logic [7:0] d, input logic extra);
    logic [7:0] r0, r1, r2, r3;
    clear_mon();
    spi_begin();
    spi_bits(8'h01, 8, r0);
    spi_bits({3'b100, a}, 8, r1);
    spi_bits(d, 8, r2);
    r3 = '0;
    if (extra) spi_bits(~d, 8, r3);
    spi_end();
    chk("R7 write count", we_cnt, 1);
    chk("R7 write addr", we_addr, a);
    chk("R7 write data", we_data, d);
    chk("R7 no read strobe", re_cnt, 0);
    chk("R6 miso low on write", {r0, r1, r2, r3}, 0);
  endtask

  task automatic t_read(input logic [4:0] a, input logic [1:0] ign);
    logic [7:0] r0, r1, r2;
    clear_mon();
    spi_begin();
    spi_bits(8'h01, 8, r0);
    spi_bits({1'b0, ign, a}, 8, r1);
    spi_bits(8'h00, 8, r2);
    spi_end();
    chk("R8 read strobe count", re_cnt, 1);
    chk("R8 read addr", re_addr, a);
    chk("R8 read data on miso", r2, rd_val(a));
    chk("R8 no write", we_cnt, 0);
  endtask

  task automatic t_ext(input logic is_dac, input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] r0, r1, r2;
    dac_miso_i = is_dac; adc_miso_i = ~is_dac;
    clear_mon();
    spi_begin();
    addr_phase = 1'b1;
    spi_bits(is_dac ? 8'h02 : 8'h03, 8, r0);
    addr_phase = 1'b0;
    chk("R3 no select during address byte", early_sel, 0);
    chk("R6 miso low in address byte", r0, 0);
    wait_clks(HALF / 2);
    chk("R3 select after address byte", is_dac ? dac_cs_no : adc_cs_no, 0);
    chk("R2 other converter idle", is_dac ? adc_cs_no : dac_cs_no, 1);
    spi_bits(b1, 8, r1);
    spi_bits(b2, 8, r2);
    chk("R6 miso follows converter", {r1, r2}, 16'hFFFF);
    wait_clks(HALF);
    cs_ni = 1'b1;
    #1;
    chk("R4 select released at once", {dac_cs_no, adc_cs_no}, 2'b11);
    wait_clks(3 * HALF);
    chk("R5 clocks forwarded", is_dac ? dac_edges : adc_edges, 16);
    chk("R5 data forwarded", is_dac ? dac_cap : adc_cap, b2);
    chk("R5 other clock quiet", is_dac ? adc_edges : dac_edges, 0);
    dac_miso_i = 1'b0; adc_miso_i = 1'b0;
  endtask

  task automatic t_unknown(input logic [7:0] code);
    logic [7:0] r0, r1, r2;
    dac_miso_i = 1'b1; adc_miso_i = 1'b1;
    clear_mon();
    spi_begin();
    spi_bits(code, 8, r0);
    spi_bits(8'h85, 8, r1);
    chk("R2 no select for unknown code", {dac_cs_no, adc_cs_no}, 2'b11);
    spi_bits(8'h5A, 8, r2);
    spi_end();
    chk("R2 miso low for unknown code", {r0, r1, r2}, 0);
    chk("R2 no clock routed", dac_edges + adc_edges, 0);
    chk("R2 no strobes", we_cnt + re_cnt, 0);
    dac_miso_i = 1'b0; adc_miso_i = 1'b0;
  endtask

  task automatic t_abort();
    logic [7:0] r;
    clear_mon();
    spi_begin();
    spi_bits(8'h01, 8, r);
    spi_bits(8'h8C, 8, r);
    spi_bits(8'hF0, 4, r);
    spi_end();
    chk("R9 aborted write discarded", we_cnt, 0);
    t_read(5'h05, 2'b00);
    clear_mon();
    spi_begin();
    spi_bits(8'h02, 4, r);
    spi_end();
    chk("R9 partial address selects nothing", dac_edges + adc_edges, 0);
    t_ext(1'b0, 8'h11, 8'h3C);
  endtask

  initial begin
    wait_clks(4);
    rst_ni = 1'b1;
    wait_clks(4);
    t_reset();
    t_write(5'h13, 8'hC6, 1'b0);
    t_write(5'h07, 8'h39, 1'b1);
    t_read(5'h0A, 2'b11);
    t_read(5'h1F, 2'b01);
    t_ext(1'b1, 8'h3C, 8'h81);
    t_ext(1'b0, 8'hA7, 8'h5E);
    t_unknown(8'h07);
    t_unknown(8'h00);
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule